// File: doc/BRIEF.md
# Multicycle Six-Phase Instruction Sequencer

This block is a small multicycle processor controller for 16-bit instructions. It keeps a program counter, an instruction register, eight 16-bit general registers and a three-bit condition register. Each instruction passes through a chain of phases: fetch, decode, address evaluation, operand fetch, execute and write-back. A state machine runs that chain and skips the phases an opcode does not need. A register-to-register add therefore takes fewer cycles than a load.

All memory traffic goes through two internal registers: a memory address register and a memory data register. A single request strobe carries a write qualifier. The request stays raised until the memory answers with a ready pulse, so the memory may add any number of wait cycles. The machine runs until it meets a stop instruction. After that it stays idle until reset.

Top module: `phase_seq`

## Requirements
- R1: A synchronous reset, at any time, sets PC to 0, clears all eight registers and the condition flags, drops the memory request and leaves the halted output low.
- R2: While a memory request is raised and ready is low, the request, the address and the write qualifier stay unchanged. Each cycle of ready held low delays completion by exactly one cycle.
- R3: Fetch reads the word at address PC. When that read completes, PC becomes PC+1.
- R4: Opcode 4'b0001 in bits [15:12] adds two registers modulo 2^16. The destination is in [11:9], the first source in [8:6] and the second source in [2:0]. The sum is written to the destination.
- R5: After an add, the flags are {gt,eq,lt}, with gt in bit 2 and lt in bit 0. They hold 3'b100 for a positive signed result, 3'b010 for zero and 3'b001 for a negative result. No other instruction changes the flags.
- R6: Opcode 4'b0110 loads a register. The destination is in [11:9] and the base register in [8:6]. The address is the base plus the 6-bit offset in [5:0], sign-extended.
- R7: Opcode 4'b0111 stores the register in [11:9] to address base [8:6] plus the sign-extended offset [5:0]. It issues exactly one write.
- R8: Opcode 4'b0100 with bit 11 clear loads PC with register [8:6] plus the sign-extended offset [5:0]. The result is truncated to the address width.
- R9: Opcode 4'b0100 with bit 11 set also writes the already incremented PC to R7. The target uses the base value from before that write, even when the base is R7.
- R10: Opcode 4'b1111 stops the machine. The halted output goes high and stays high, no further memory requests are made, and PC stays fixed until reset.
- R11: Any other opcode changes no register, no flag and no memory word. Execution continues at the next address.
- R12: With no wait cycles, add and jump take 4 cycles, store takes 5, load takes 6, other opcodes take 3, and the stop instruction reaches halted 3 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | AW | Memory address register |
| mem_wdata | output | 16 | Memory data register toward memory |
| mem_rdata | input | 16 | Read data from memory |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Write qualifier for the request |
| mem_rdy | input | 1 | Memory has completed the request |
| pc | output | AW | Program counter |
| flags | output | 3 | Condition flags {gt,eq,lt} |
| halted | output | 1 | Machine has stopped |

## Verification
The bench builds the block with AW=8. A 256-word memory model then covers the whole address space, so the jump targets and the negative load offsets fall within the modelled memory. Each add vector runs a complete load-load-add-store program, with 0, 1 or 2 wait cycles per access. This exercises the cycle counts together with the arithmetic and the flags. The overflow vectors check that a signed overflow sets the flags from the truncated sum.

// File: rtl/phase_seq.sv
module phase_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  input  logic          mem_rdy,
  output logic [AW-1:0] pc,
  output logic [2:0]    flags,
  output logic          halted
);
  typedef enum logic [2:0] {
    FETCH, IFWAIT, DECODE, EVADDR, MEMWAIT, EXEC, WBACK, STOP
  } st_t;

  localparam logic [3:0] OP_ADD  = 4'b0001;
  localparam logic [3:0] OP_JMP  = 4'b0100;
  localparam logic [3:0] OP_LDR  = 4'b0110;
  localparam logic [3:0] OP_STR  = 4'b0111;
  localparam logic [3:0] OP_STOP = 4'b1111;

  st_t         st;
  logic [15:0] ir, mdr;
  logic [AW-1:0] mar;
  logic [15:0] rf [8];

  logic [3:0]  op;
  logic [15:0] off16, ea, sum, pc_ext;

  assign op    = ir[15:12];
  assign off16 = {{10{ir[5]}}, ir[5:0]};
  assign ea    = rf[ir[8:6]] + off16;
  assign sum   = rf[ir[8:6]] + rf[ir[2:0]];

  always_comb begin
    pc_ext = '0;
    pc_ext[AW-1:0] = pc;
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_req   = (st == IFWAIT) || (st == MEMWAIT);
  assign mem_we    = (st == MEMWAIT) && (op == OP_STR);
  assign halted    = (st == STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= FETCH;
      pc    <= '0;
      ir    <= '0;
      mdr   <= '0;
      mar   <= '0;
      flags <= '0;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else begin
      case (st)
        FETCH: begin
          mar <= pc;
          st  <= IFWAIT;
        end
        IFWAIT: if (mem_rdy) begin
          ir <= mem_rdata;
          pc <= pc + AW'(1);
          st <= DECODE;
        end
        DECODE: begin
          case (op)
            OP_ADD, OP_JMP: st <= EXEC;
            OP_LDR, OP_STR: st <= EVADDR;
            OP_STOP:        st <= STOP;
            default:        st <= FETCH;
          endcase
        end
        EVADDR: begin
          mar <= ea[AW-1:0];
          mdr <= rf[ir[11:9]];
          st  <= MEMWAIT;
        end
        MEMWAIT: if (mem_rdy) begin
          if (op == OP_LDR) begin
            mdr <= mem_rdata;
            st  <= WBACK;
          end else begin
            st <= FETCH;
          end
        end
        WBACK: begin
          rf[ir[11:9]] <= mdr;
          st <= FETCH;
        end
        EXEC: begin
          if (op == OP_ADD) begin
            rf[ir[11:9]] <= sum;
            flags <= {~sum[15] && (sum != 16'd0), sum == 16'd0, sum[15]};
          end else begin
            pc <= ea[AW-1:0];
            if (ir[11]) rf[7] <= pc_ext;
          end
          st <= FETCH;
        end
        STOP:    st <= STOP;
        default: st <= FETCH;
      endcase
    end
  end

  a_r2_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    (st == IFWAIT && mem_rdy) |=> (pc == $past(pc) + AW'(1)));

  a_r7_write_in_request: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    (st == EXEC && op == OP_JMP) |=> (pc == $past(ea[AW-1:0])));

  a_r10_stop_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_req && $stable(pc)));
endmodule

// File: tb/phase_seq_bench.sv
`timescale 1ns/1ps
module phase_seq_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata, mem_rdata;
  logic          mem_req, mem_we, mem_rdy;
  logic [AW-1:0] pc;
  logic [2:0]    flags;
  logic          halted;

  int nchk = 0;
  int nerr = 0;

  logic [15:0] mem [256];
  logic [15:0] img [256];
  logic        load = 1'b0;
  int          wait_n = 0;
  int          wc = 0;
  int          wcnt = 0;

  always #10 clk = ~clk;

  phase_seq #(.AW(AW)) u_phase_seq (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_rdy(mem_rdy), .pc(pc), .flags(flags), .halted(halted));

  assign mem_rdy   = mem_req && (wc >= wait_n);
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < 256; i++) mem[i] <= img[i];
      wcnt <= 0;
      wc   <= 0;
    end else begin
      if (mem_req && !mem_rdy) wc <= wc + 1;
      else wc <= 0;
      if (mem_req && mem_we && mem_rdy) begin
        mem[mem_addr] <= mem_wdata;
        wcnt <= wcnt + 1;
      end
    end
  end

  // a, b, expected sum, expected flags {gt,eq,lt}
  localparam logic [50:0] VEC [8] = '{
    {16'd5,    16'd7,    16'd12,   3'b100},
    {16'd0,    16'd0,    16'd0,    3'b010},
    {16'd3,    16'hFFFD, 16'd0,    3'b010},
    {16'h7FFF, 16'd1,    16'h8000, 3'b001},
    {16'hFFFF, 16'hFFFF, 16'hFFFE, 3'b001},
    {16'h8000, 16'h8000, 16'h0000, 3'b010},
    {16'hFFF6, 16'd4,    16'hFFFA, 3'b001},
    {16'd100,  16'd200,  16'd300,  3'b100}
  };

  function automatic logic [15:0] e_add(input logic [2:0] d, input logic [2:0] a, input logic [2:0] b);
    return {4'b0001, d, a, 3'b000, b};
  endfunction
  function automatic logic [15:0] e_ldr(input logic [2:0] d, input logic [2:0] b, input logic [5:0] o);
    return {4'b0110, d, b, o};
  endfunction
  function automatic logic [15:0] e_str(input logic [2:0] s, input logic [2:0] b, input logic [5:0] o);
    return {4'b0111, s, b, o};
  endfunction
  function automatic logic [15:0] e_jmp(input logic lk, input logic [2:0] b, input logic [5:0] o);
    return {4'b0100, lk, 2'b00, b, o};
  endfunction
  localparam logic [15:0] E_STOP = 16'hF000;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic clr_img();
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst  = 1'b1;
    load = 1'b1;
    @(negedge clk);
    @(negedge clk);
    load = 1'b0;
    rst  = 1'b0;
  endtask

  task automatic run(output int n);
    n = 0;
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (halted) return;
    end
    chk("R10 run reached stop", 0, 1);
  endtask

  initial begin
    #4000000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int n;
    int still;

    // R1 reset state
    clr_img();
    img[0] = E_STOP;
    wait_n = 3;
    do_reset();
    chk("R1 pc after reset", pc, 0);
    chk("R1 req after reset", mem_req, 0);
    chk("R1 halted after reset", halted, 0);
    chk("R1 flags after reset", flags, 0);

    // R2 / R3 fetch with three wait cycles
    for (int e = 1; e <= 4; e++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R2 req held", mem_req, 1);
      chk("R3 fetch address", mem_addr, 0);
      chk("R2 no write on fetch", mem_we, 0);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R3 pc incremented", pc, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R10 halted after stop", halted, 1);

    // R4 R5 R7 R12 vector table
    for (int i = 0; i < 8; i++) begin
      clr_img();
      img[0]  = e_ldr(3'd1, 3'd0, 6'd20);
      img[1]  = e_ldr(3'd2, 3'd0, 6'd21);
      img[2]  = e_add(3'd3, 3'd1, 3'd2);
      img[3]  = e_str(3'd3, 3'd0, 6'd22);
      img[4]  = E_STOP;
      img[20] = VEC[i][50:35];
      img[21] = VEC[i][34:19];
      wait_n  = i % 3;
      do_reset();
      run(n);
      chk("R4 sum stored", mem[22], VEC[i][18:3]);
      chk("R5 flags", flags, VEC[i][2:0]);
      chk("R12 cycle count", n, 24 + 8 * wait_n);
      chk("R7 single write", wcnt, 1);
    end

    // R1 reset in mid-program
    wait_n = 2;
    do_reset();
    for (int e = 0; e < 5; e++) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 pc on mid reset", pc, 0);
    chk("R1 req on mid reset", mem_req, 0);
    chk("R1 flags on mid reset", flags, 0);
    rst = 1'b0;
    run(n);
    chk("R1 rerun result", mem[22], 16'd300);

    // R6 negative offset load
    clr_img();
    img[0]  = e_ldr(3'd4, 3'd0, 6'd10);
    img[1]  = e_ldr(3'd5, 3'd4, 6'b111000);
    img[2]  = e_str(3'd5, 3'd0, 6'd23);
    img[3]  = E_STOP;
    img[10] = 16'd40;
    img[32] = 16'hBEEF;
    wait_n  = 0;
    do_reset();
    run(n);
    chk("R6 negative offset load", mem[23], 16'hBEEF);
    chk("R12 load load store", n, 6 + 6 + 5 + 3);

    // R8 jump without link
    clr_img();
    img[0]  = e_ldr(3'd6, 3'd0, 6'd11);
    img[1]  = e_jmp(1'b0, 3'd6, 6'd2);
    img[2]  = e_str(3'd6, 3'd0, 6'd24);
    img[50] = E_STOP;
    img[11] = 16'd48;
    do_reset();
    run(n);
    chk("R8 pc after jump", pc, 51);
    chk("R8 skipped store", wcnt, 0);
    chk("R12 jump cycles", n, 6 + 4 + 3);

    // R9 jump with link through R7
    clr_img();
    img[0]  = e_ldr(3'd7, 3'd0, 6'd11);
    img[1]  = e_jmp(1'b1, 3'd7, 6'd4);
    img[52] = e_str(3'd7, 3'd0, 6'd25);
    img[53] = E_STOP;
    img[11] = 16'd48;
    do_reset();
    run(n);
    chk("R9 link value", mem[25], 16'd2);
    chk("R9 pc after linked jump", pc, 54);

    // R11 other opcodes are no-ops, R5 flags kept
    clr_img();
    img[0]  = e_ldr(3'd1, 3'd0, 6'd20);
    img[1]  = e_add(3'd2, 3'd1, 3'd1);
    img[2]  = 16'h3FFF;
    img[3]  = 16'hA5C3;
    img[4]  = e_str(3'd2, 3'd0, 6'd22);
    img[5]  = e_str(3'd1, 3'd0, 6'd23);
    img[6]  = E_STOP;
    img[20] = 16'd5;
    do_reset();
    run(n);
    chk("R11 sum register kept", mem[22], 16'd10);
    chk("R11 source register kept", mem[23], 16'd5);
    chk("R5 flags kept by others", flags, 3'b100);
    chk("R11 writes", wcnt, 2);
    chk("R11 pc", pc, 7);
    chk("R12 mixed cycles", n, 6 + 4 + 3 + 3 + 5 + 5 + 3);

    // R10 stays halted
    still = 1;
    for (int e = 0; e < 20; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (mem_req || !halted || pc != 7) still = 0;
    end
    chk("R10 idle after stop", still, 1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule